// File: doc/BRIEF.md
# Request Stream Framing Monitor

This block is a passive observer on a request-side AXI4-Stream link. It sits between a user-logic producer and a link-side consumer. It samples the valid/ready handshake, the data bus, the per-Dword keep mask, the end-of-packet marker and the sideband user bits. It never drives or alters the stream. It follows packet boundaries using the handshake and the end marker, and it reports framing violations as sticky error bits.

The producer must hold valid high from the first beat of a packet until the end-marked beat is accepted. If valid falls inside a packet, the monitor raises a one-cycle nullify pulse so that the downstream logic can discard the request in flight. The producer must also hold every stream field steady while the consumer stalls. The keep mask must be a run of ones that starts at Dword lane 0 and continues without a gap to the last valid Dword. The consumer may lower ready on any cycle, and that alone is never an error. The bus width is a parameter, with one keep bit per 32-bit lane.

Top module: `rqs_framing_monitor`

## Requirements
- R1: After reset, `err_o` is 0, `nullify_o` is 0 and `in_pkt_o` is 0.
- R2: `in_pkt_o` goes to 1 one cycle after a beat is accepted (valid and ready both high) with `s_last` low. It returns to 0 one cycle after a beat is accepted with `s_last` high. A packet of a single end-marked beat leaves it at 0.
- R3: When `s_valid` is low while `in_pkt_o` is 1, `err_o[0]` is set on the next cycle and `nullify_o` pulses high for exactly one cycle. Further valid drops in the same packet produce no more pulses. A later packet can pulse again.
- R4: `s_ready` low on any cycle, and `s_valid` low outside a packet, set no error bit.
- R5: If the previous cycle had `s_valid` high and `s_ready` low, and in this cycle `s_valid` is high but `s_data`, `s_keep`, `s_last` or `s_user` differs from its previous value, `err_o[1]` is set on the next cycle. Holding every field unchanged sets nothing.
- R6: An accepted beat with `s_last` low and any zero bit in `s_keep` sets `err_o[2]` on the next cycle.
- R7: An accepted beat with `s_last` high sets `err_o[3]` on the next cycle unless `s_keep` is nonzero, has bit 0 set, and has no one above a zero (a value of the form 2^n-1).
- R8: Error bits are sticky until `clr_i` is high. `clr_i` clears all bits on the next cycle, but a violation detected in the same cycle as `clr_i` still sets its bit.
- R9: Each violation sets only its own bit in `err_o`: bit 0 is valid drop, bit 1 is hold change, bit 2 is a keep gap on a non-last beat, and bit 3 is a bad keep on the last beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Clears the sticky error bits |
| s_valid | input | 1 | Stream valid (observed) |
| s_ready | input | 1 | Stream ready from the consumer (observed) |
| s_data | input | DATA_W | Stream data (observed) |
| s_keep | input | DATA_W/32 | Per-Dword keep mask (observed) |
| s_last | input | 1 | End-of-packet marker (observed) |
| s_user | input | USER_W | Sideband user bits (observed) |
| err_o | output | 4 | Sticky violation flags, one bit per rule |
| nullify_o | output | 1 | One-cycle pulse that requests discarding the current packet |
| in_pkt_o | output | 1 | High while a packet is open |

## Verification
The embedded assertions check four things on every cycle. They check that the nullify pulse lasts one cycle and always comes with the valid-drop flag. They check that error bits are never lost without a clear. They check that each flag rises only after the kind of cycle that can cause it: a stall for hold errors, an accepted non-last beat for keep gaps, and an accepted last beat for bad tail masks. They also check that accepting an end beat closes the packet. Only the bench scenarios show the arithmetic side of the rules. These are the full sweeps of every keep value on middle and last beats, a change to each stream field in turn during a stall, the single pulse per poisoned packet, and the re-arming of the pulse in a later packet.

// File: rtl/rqs_mon_pkg.sv
package rqs_mon_pkg;
  localparam int ERR_W         = 4;
  localparam int ERR_VLD_DROP  = 0;
  localparam int ERR_HOLD      = 1;
  localparam int ERR_KEEP_MID  = 2;
  localparam int ERR_KEEP_TAIL = 3;
endpackage

// File: rtl/rqs_pkt_tracker.sv
module rqs_pkt_tracker (
  input  logic clk,
  input  logic rst,
  input  logic valid,
  input  logic ready,
  input  logic last,
  output logic in_pkt,
  output logic drop_det,
  output logic first_drop
);
  logic poisoned;
  logic accept;

  assign accept     = valid && ready;
  assign drop_det   = in_pkt && !valid;
  assign first_drop = drop_det && !poisoned;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_pkt   <= 1'b0;
      poisoned <= 1'b0;
    end else begin
      if (accept) in_pkt <= !last;
      if (accept && last) poisoned <= 1'b0;
      else if (drop_det)  poisoned <= 1'b1;
    end
  end

  AST_PKT_CLOSE: assert property (@(posedge clk) disable iff (rst)
    (valid && ready && last) |=> !in_pkt); // R2
endmodule

// File: rtl/rqs_hold_check.sv
module rqs_hold_check #(
  parameter int BUS_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             valid,
  input  logic             ready,
  input  logic [BUS_W-1:0] bus,
  output logic             change_det
);
  logic             stalled_q;
  logic [BUS_W-1:0] snap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stalled_q <= 1'b0;
      snap_q    <= '0;
    end else begin
      stalled_q <= valid && !ready;
      snap_q    <= bus;
    end
  end

  assign change_det = stalled_q && valid && (bus != snap_q);
endmodule

// File: rtl/rqs_keep_check.sv
module rqs_keep_check #(
  parameter int LANES = 2
) (
  input  logic             valid,
  input  logic             ready,
  input  logic             last,
  input  logic [LANES-1:0] keep,
  output logic             mid_det,
  output logic             tail_det
);
  logic [LANES-1:0] rise;
  logic             accept;

  assign accept = valid && ready;

  // A lane is a rise when it is kept but the lane below is not; lane 0 counts when it is empty.
  assign rise[0] = !keep[0];
  for (genvar i = 1; i < LANES; i++) begin : g_lane
    assign rise[i] = keep[i] && !keep[i-1];
  end

  assign mid_det  = accept && !last && !(&keep);
  assign tail_det = accept &&  last && (|rise);
endmodule

// File: rtl/rqs_framing_monitor.sv
module rqs_framing_monitor
  import rqs_mon_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int USER_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                clr_i,
  input  logic                s_valid,
  input  logic                s_ready,
  input  logic [DATA_W-1:0]   s_data,
  input  logic [DATA_W/32-1:0] s_keep,
  input  logic                s_last,
  input  logic [USER_W-1:0]   s_user,
  output logic [ERR_W-1:0]    err_o,
  output logic                nullify_o,
  output logic                in_pkt_o
);
  localparam int LANES = DATA_W / 32;
  localparam int BUS_W = DATA_W + LANES + 1 + USER_W;

  logic             drop_det, first_drop, change_det, mid_det, tail_det;
  logic [ERR_W-1:0] det;

  rqs_pkt_tracker u_trk (
    .clk(clk), .rst(rst), .valid(s_valid), .ready(s_ready), .last(s_last),
    .in_pkt(in_pkt_o), .drop_det(drop_det), .first_drop(first_drop)
  );

  rqs_hold_check #(.BUS_W(BUS_W)) u_hold (
    .clk(clk), .rst(rst), .valid(s_valid), .ready(s_ready),
    .bus({s_data, s_keep, s_last, s_user}), .change_det(change_det)
  );

  rqs_keep_check #(.LANES(LANES)) u_keep (
    .valid(s_valid), .ready(s_ready), .last(s_last), .keep(s_keep),
    .mid_det(mid_det), .tail_det(tail_det)
  );

  always_comb begin
    det                = '0;
    det[ERR_VLD_DROP]  = drop_det;
    det[ERR_HOLD]      = change_det;
    det[ERR_KEEP_MID]  = mid_det;
    det[ERR_KEEP_TAIL] = tail_det;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_o     <= '0;
      nullify_o <= 1'b0;
    end else begin
      err_o     <= (clr_i ? '0 : err_o) | det;
      nullify_o <= first_drop;
    end
  end

  AST_NULL_SINGLE: assert property (@(posedge clk) disable iff (rst)
    nullify_o |=> !nullify_o); // R3
  AST_NULL_FLAGGED: assert property (@(posedge clk) disable iff (rst)
    nullify_o |-> err_o[ERR_VLD_DROP]); // R3
  AST_STICKY: assert property (@(posedge clk) disable iff (rst)
    !clr_i |=> ((err_o & $past(err_o)) == $past(err_o))); // R8
  AST_HOLD_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(err_o[ERR_HOLD]) |-> ($past(s_valid) && $past(s_valid && !s_ready, 2))); // R5
  AST_MID_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(err_o[ERR_KEEP_MID]) |-> $past(s_valid && s_ready && !s_last)); // R6
  AST_TAIL_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(err_o[ERR_KEEP_TAIL]) |-> $past(s_valid && s_ready && s_last)); // R7
endmodule

// File: tb/rqs_framing_monitor_tb.sv
`timescale 1ns/1ps
module rqs_framing_monitor_tb_top;
  localparam int DW = 128;
  localparam int UW = 8;
  localparam int LN = DW / 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clr_i = 1'b0;
  logic          s_valid = 1'b0, s_ready = 1'b0, s_last = 1'b0;
  logic [DW-1:0] s_data = '0;
  logic [LN-1:0] s_keep = '0;
  logic [UW-1:0] s_user = '0;
  logic [3:0]    err_o;
  logic          nullify_o, in_pkt_o;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  rqs_framing_monitor #(.DATA_W(DW), .USER_W(UW)) dut_i (
    .clk(clk), .rst(rst), .clr_i(clr_i), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_keep(s_keep), .s_last(s_last), .s_user(s_user),
    .err_o(err_o), .nullify_o(nullify_o), .in_pkt_o(in_pkt_o)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic r, input logic [LN-1:0] k, input logic l);
    s_valid = v; s_ready = r; s_keep = k; s_last = l;
  endtask

  task automatic idle_clear();
    drive(1'b0, 1'b1, '0, 1'b0);
    clr_i = 1'b1; tick(); clr_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst = 1'b0; tick();
    chk("R1 err after reset", 32'(err_o), 0);
    chk("R1 nullify after reset", 32'(nullify_o), 0);
    chk("R1 in_pkt after reset", 32'(in_pkt_o), 0);

    // single-beat packet
    drive(1, 1, 4'b0001, 1); tick();
    chk("R2 single beat in_pkt", 32'(in_pkt_o), 0);
    chk("R7 single beat keep ok", 32'(err_o), 0);

    // two-beat packet with backpressure
    s_data = {4{32'h1111_2222}}; s_user = 8'h5A;
    drive(1, 0, 4'b1111, 0); tick();
    drive(1, 0, 4'b1111, 0); tick();
    chk("R4 stall no error", 32'(err_o), 0);
    chk("R2 not open before accept", 32'(in_pkt_o), 0);
    drive(1, 1, 4'b1111, 0); tick();
    chk("R2 open after first beat", 32'(in_pkt_o), 1);
    s_data = {4{32'h3333_4444}};
    drive(1, 0, 4'b0011, 1); tick();
    drive(1, 1, 4'b0011, 1); tick();
    chk("R2 closed after last", 32'(in_pkt_o), 0);
    chk("R5 steady hold no error", 32'(err_o), 0);
    drive(0, 0, '0, 0); repeat (3) tick();
    chk("R4 idle valid low", 32'(err_o), 0);

    // valid drop mid-packet
    drive(1, 1, 4'b1111, 0); tick();
    drive(0, 1, 4'b1111, 0); tick();
    chk("R3 drop flag", 32'(err_o), 1);
    chk("R3 nullify pulse", 32'(nullify_o), 1);
    tick();
    chk("R3 pulse one cycle", 32'(nullify_o), 0);
    drive(1, 1, 4'b1111, 0); tick();
    drive(0, 1, 4'b1111, 0); tick();
    chk("R3 no second pulse", 32'(nullify_o), 0);
    drive(1, 1, 4'b1111, 1); tick();
    chk("R2 closed after poisoned", 32'(in_pkt_o), 0);
    drive(0, 1, '0, 0); repeat (4) tick();
    chk("R8 sticky", 32'(err_o), 1);
    idle_clear(); tick();
    chk("R8 cleared", 32'(err_o), 0);
    drive(1, 1, 4'b1111, 0); tick();
    drive(0, 1, 4'b1111, 0); tick();
    chk("R3 rearmed pulse", 32'(nullify_o), 1);
    drive(1, 1, 4'b1111, 1); tick();
    idle_clear();

    // clear and new violation in same cycle
    drive(1, 1, 4'b0101, 1); clr_i = 1'b1; tick(); clr_i = 1'b0;
    chk("R8 set wins over clear", 32'(err_o), 4'b1000);
    idle_clear();

    // hold change sweep, one field at a time
    for (int f = 0; f < 4; f++) begin
      s_data = {4{32'hCAFE_0000}}; s_user = 8'h11;
      drive(1, 0, 4'b0111, 1); tick();
      chk("R5 stall steady", 32'(err_o), 0);
      case (f)
        0: s_data[5] = ~s_data[5];
        1: s_keep = 4'b0011;
        2: s_last = 1'b0;
        default: s_user = 8'h12;
      endcase
      tick();
      chk($sformatf("R5 R9 hold change field %0d", f), 32'(err_o), 4'b0010);
      drive(0, 1, '0, 0); tick();
      chk("R4 drop while stalled outside packet", 32'(err_o), 4'b0010);
      idle_clear();
    end

    // middle-beat keep sweep
    for (int k = 0; k < 16; k++) begin
      drive(1, 1, 4'(k), 0); tick();
      chk($sformatf("R6 R9 mid keep %0h", k), 32'(err_o), (k == 15) ? 0 : 4'b0100);
      drive(1, 1, 4'b1111, 1); tick();
      idle_clear();
    end

    // last-beat keep sweep
    for (int k = 0; k < 16; k++) begin
      bit ok;
      ok = (k != 0) && ((k & (k + 1)) == 0);
      drive(1, 1, 4'(k), 1); tick();
      chk($sformatf("R7 R9 tail keep %0h", k), 32'(err_o), ok ? 0 : 4'b1000);
      idle_clear();
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule